// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs, sitting behind a small 32-bit register bus. Software sets up a PHY address, a register or device address, an operation and a framing selector, and writes them to the command register with the start bit set. The block then generates the serial clock from the system clock, shifts out one complete management frame, and releases the data line during the turnaround and data fields of a read so the PHY can answer. Both the short-address framing (Clause 22) and the extended framing (Clause 45) are supported. Extended accesses are built from two commands: an address frame and then a data frame.

The start bit doubles as the busy flag. It reads 1 for the whole frame and drops by itself when the last bit has gone out. A read leaves its 16-bit result in the read-data register. It also updates a failure flag in the status register, which is set when no PHY pulled the line low in the second turnaround bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and the MDIO output enable is low.
- R2: Command register (offset 0x00) fields: bits [4:0] register/device address, [9:5] PHY address, [11:10] operation, [13:12] framing selector, bit 14 start. Reading it returns the stored fields in those bits, with bit 14 showing the busy state. Address register is at 0x04, write data at 0x08, read data at 0x0C and status at 0x10, each with its data in bits [15:0].
- R3: A frame is 64 bits, sent MSB first: 32 ones, then a start pattern, the 2-bit operation field as written, the PHY address, the register/device address, 2 turnaround bits and 16 data bits. The start pattern is 01 when the selector is 1 and 00 for any other selector value.
- R4: An extended-framing address operation (selector 0, operation 0) carries the address register as its data field. Every other driven frame carries the write-data register.
- R5: A non-read frame drives turnaround as 1 then 0, with the output enable high for all 64 bits.
- R6: A read is selector 1 with operation 2, or any other selector with operation 2 or 3. The output enable is high for bits 0 to 45 and low from the first turnaround bit to the end. The 16 bits sampled at bit positions 48..63, MSB first, land in the read-data register.
- R7: Status bit 0 takes the value sampled from MDIO in the second turnaround bit of each read (1 means failed). Non-read frames leave it unchanged.
- R8: The start bit reads 1 for exactly 64*CLK_DIV clock cycles after a command write with bit 14 set.
- R9: A command write while the start bit is 1 is ignored: the stored fields and the frame in progress do not change.
- R10: MDC is low while idle and has a period of CLK_DIV system clocks during a frame. MDIO output changes after the falling MDC edge and input is sampled at the rising edge.
- R11: A command write with bit 14 clear stores the fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data, output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data, input value |

## Verification
A wrong bit counter or shift register shows at the ports within one MDC period as a misplaced bit, and the bench compares every one of the 64 bits sampled at the rising MDC edges against a frame it assembles from the command fields. A wrong read decode shows first as an output enable that stays high or drops at bit 46. A wrong capture shows as a read-data or status value that differs right after the start bit clears. The busy length is counted to the exact cycle. Any slip in the divider or the end-of-frame detection therefore appears in the first frame.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management master.
// Assumes byte offsets on a 5-bit register address.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam logic [5:0] TA_FIRST  = 6'd46;
    localparam logic [5:0] TA_SECOND = 6'd47;
    localparam logic [5:0] DATA_FIRST = 6'd48;
    localparam logic [5:0] LAST_BIT  = 6'd63;

    localparam logic [4:0] OFS_CMD   = 5'h00;
    localparam logic [4:0] OFS_ADDR  = 5'h04;
    localparam logic [4:0] OFS_WDATA = 5'h08;
    localparam logic [4:0] OFS_RDATA = 5'h0C;
    localparam logic [4:0] OFS_STAT  = 5'h10;

    // Command fields as held in bits [13:0] of the command register.
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dev;
    } cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
// Produces MDC from the system clock while run is high, plus single-cycle
// events that mark the clock edge at which MDC rises or falls.
// Assumes DIV is even and at least 2; MDC is held low while run is low.
module mdio_clkdiv #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] hc;
    logic          wrap;

    assign wrap    = (hc == CW'(HALF - 1));
    assign rise_ev = run && wrap && !mdc;
    assign fall_ev = run && wrap && mdc;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hc  <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            hc  <= '0;
            mdc <= ~mdc;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    a_r10_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_ev && fall_ev));
endmodule

// File: rtl/mdio_frame.sv
// Shifts one 64-bit management frame out and, for reads, samples the
// turnaround flag and 16 data bits in. Starts on a start pulse while idle.
// Assumes the rise/fall events come from mdio_clkdiv running on busy.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cmd_t        cmd,
    input  logic [15:0] addr_val,
    input  logic [15:0] wdata_val,
    input  logic        rise_ev,
    input  logic        fall_ev,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        is_rd,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_val,
    output logic        rd_fail
);
    logic [FRAME_BITS-1:0] sh;
    logic [5:0]            bitn;
    logic                  c22, cmd_rd;
    logic [1:0]            st_pat;
    logic [15:0]           payload;

    // Decode framing, read type and payload source from the new command.
    always_comb begin
        c22     = (cmd.sel == 2'd1);
        st_pat  = c22 ? 2'b01 : 2'b00;
        cmd_rd  = c22 ? (cmd.op == 2'd2) : cmd.op[1];
        payload = (!c22 && cmd.op == 2'd0) ? addr_val : wdata_val;
    end

    assign done    = busy && fall_ev && (bitn == LAST_BIT);
    assign mdio_o  = busy ? sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy && !(is_rd && bitn >= TA_FIRST);

    // Frame shifter and bit counter, advanced on the falling MDC event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            bitn  <= '0;
            sh    <= '1;
            is_rd <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                bitn  <= '0;
                is_rd <= cmd_rd;
                sh    <= {32'hFFFF_FFFF, st_pat, cmd.op, cmd.port, cmd.dev,
                          2'b10, payload};
            end
        end else if (fall_ev) begin
            sh <= {sh[FRAME_BITS-2:0], 1'b1};
            if (bitn == LAST_BIT) busy <= 1'b0;
            else                  bitn <= bitn + 1'b1;
        end
    end

    // Input capture on the rising MDC event during a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_val  <= '0;
            rd_fail <= 1'b0;
        end else if (start && !busy) begin
            rd_fail <= 1'b0;
        end else if (busy && is_rd && rise_ev) begin
            if (bitn == TA_SECOND)   rd_fail <= mdio_i;
            if (bitn >= DATA_FIRST)  rd_val  <= {rd_val[14:0], mdio_i};
        end
    end

    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r3_preamble_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bitn < 6'd32) |-> (mdio_o && mdio_oe));
    a_r10_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_ev) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_mgmt_master.sv
// Register front end of the management master: decodes the five registers,
// launches frames and stores read results. Assumes single-cycle writes and
// combinational reads; the start bit of the command register is the busy flag.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cmd_t        cmd_q;
    logic [15:0] addr_q, wdata_q, rdata_q;
    logic        fail_q;
    logic        busy, frm_done, frm_rd, rise_ev, fall_ev, rd_fail;
    logic [15:0] rd_val;
    logic        cmd_wr, launch;
    logic        unused_wbits;

    assign unused_wbits = ^bus_wdata[31:15];
    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD) && !busy;
    assign launch = cmd_wr && bus_wdata[14];

    // Writable registers and the read result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (cmd_wr) cmd_q <= cmd_t'(bus_wdata[13:0]);
            if (bus_wr && bus_addr == OFS_ADDR)  addr_q  <= bus_wdata[15:0];
            if (bus_wr && bus_addr == OFS_WDATA) wdata_q <= bus_wdata[15:0];
            if (frm_done && frm_rd) begin
                rdata_q <= rd_val;
                fail_q  <= rd_fail;
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_CMD:   bus_rdata = {17'd0, busy, cmd_q};
            OFS_ADDR:  bus_rdata = {16'd0, addr_q};
            OFS_WDATA: bus_rdata = {16'd0, wdata_q};
            OFS_RDATA: bus_rdata = {16'd0, rdata_q};
            OFS_STAT:  bus_rdata = {31'd0, fail_q};
            default:   bus_rdata = '0;
        endcase
    end

    mdio_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .start(launch),
        .cmd(cmd_t'(bus_wdata[13:0])), .addr_val(addr_q), .wdata_val(wdata_q),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
        .busy(busy), .done(frm_done), .is_rd(frm_rd),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_val(rd_val), .rd_fail(rd_fail)
    );

    a_r9_cmd_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && busy) |=> $stable(cmd_q));
    a_r7_status_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_done && frm_rd) |=> $stable(fail_q));
    a_r1_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdio_mgmt_master #(.CLK_DIV(DIV)) i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_i)
    );

    // PHY model and line capture.
    logic [63:0] cap_o, cap_oe;
    int          cap_n = 0;
    int          fc = 0;
    logic [15:0] phy_resp = '0;
    logic        phy_ta = 1'b0;
    realtime     last_t = 0;
    logic        per_bad = 1'b0;

    function automatic logic phy_bit(int k);
        if (k == 47) return phy_ta;
        if (k >= 48 && k <= 63) return phy_resp[63-k];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (cap_n < 64) begin
            cap_o[63-cap_n]  = mdio_o;
            cap_oe[63-cap_n] = mdio_oe;
            if (cap_n > 0 && ($realtime - last_t) != DIV * 10.0) per_bad = 1'b1;
            last_t = $realtime;
            cap_n++;
        end
    end

    always @(negedge mdc) begin
        fc++;
        phy_i = phy_bit(fc);
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h00;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 5'h00;
    endtask

    // Launch one command, count busy cycles, compare the captured frame.
    task automatic run_frame(input logic [1:0] sel, input logic [1:0] op,
                             input logic [4:0] port, input logic [4:0] dev,
                             input logic [15:0] payload, input bit rd,
                             input logic ta, input logic [15:0] resp,
                             input bit inject);
        logic [63:0] exp_f, exp_oe, mask;
        logic [31:0] v;
        int n;
        cap_n = 0; fc = 0; per_bad = 1'b0;
        phy_ta = ta; phy_resp = resp; phy_i = 1'b1;
        reg_wr(5'h00, {17'd0, 1'b1, sel, op, port, dev});
        n = 0;
        forever begin
            reg_rd(5'h00, v);
            if (!v[14]) break;
            if (inject && n == 10) begin
                bus_wr = 1'b1; bus_wdata = {17'd0, 1'b1, ~sel, ~op, ~port, ~dev};
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        bus_wr = 1'b0;
        check(n == 64 * DIV, "R8 busy length", 64'(n), 64'(64 * DIV));
        check(!per_bad && cap_n == 64, "R10 mdc period", 64'(cap_n), 64'd64);
        exp_f  = {32'hFFFF_FFFF, (sel == 2'd1) ? 2'b01 : 2'b00, op, port, dev,
                  2'b10, payload};
        mask   = rd ? {46'h3FFF_FFFF_FFFF, 18'd0} : '1;
        exp_oe = mask;
        check((cap_o & mask) == (exp_f & mask), rd ? "R3 R6 read frame" : "R3 R4 R5 frame",
              cap_o & mask, exp_f & mask);
        check(cap_oe == exp_oe, rd ? "R6 oe release" : "R5 oe driven", cap_oe, exp_oe);
        reg_rd(5'h00, v);
        check(v == {17'd0, 1'b0, sel, op, port, dev},
              inject ? "R9 fields kept" : "R2 command readback", 64'(v),
              64'({17'd0, 1'b0, sel, op, port, dev}));
        if (rd) begin
            reg_rd(5'h10, v);
            check(v == {31'd0, ta}, "R7 status", 64'(v), 64'(ta));
            if (!ta) begin
                reg_rd(5'h0C, v);
                check(v == {16'd0, resp}, "R6 read data", 64'(v), 64'(resp));
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        foreach (v[i]) begin end
        for (int a = 0; a <= 16; a += 4) begin
            reg_rd(5'(a), v);
            check(v == 32'd0, "R1 reset register", 64'(v), 64'd0);
        end
        check(!mdc && !mdio_oe, "R1 idle lines", {62'd0, mdc, mdio_oe}, 64'd0);

        reg_wr(5'h04, 32'h0000_A55A);
        reg_wr(5'h08, 32'h0000_3C96);
        reg_rd(5'h04, v);
        check(v == 32'hA55A, "R2 address register", 64'(v), 64'hA55A);
        reg_rd(5'h08, v);
        check(v == 32'h3C96, "R2 write data register", 64'(v), 64'h3C96);

        // Clause 22 writes over corner addresses
        for (int p = 0; p < 3; p++)
            for (int d = 0; d < 3; d++)
                run_frame(2'd1, 2'd1, (p == 0) ? 5'd0 : (p == 1) ? 5'd5 : 5'd31,
                          (d == 0) ? 5'd0 : (d == 1) ? 5'd17 : 5'd31,
                          16'h3C96, 1'b0, 1'b0, 16'h0, 1'b0);
        // Extended address frame carries the address register (R4)
        run_frame(2'd0, 2'd0, 5'd9, 5'd3, 16'hA55A, 1'b0, 1'b0, 16'h0, 1'b0);
        // Extended write, and selector 2 using extended framing (R3)
        run_frame(2'd0, 2'd1, 5'd9, 5'd3, 16'h3C96, 1'b0, 1'b0, 16'h0, 1'b0);
        run_frame(2'd2, 2'd1, 5'd1, 5'd2, 16'h3C96, 1'b0, 1'b0, 16'h0, 1'b0);
        // Reads of each kind (R6)
        run_frame(2'd1, 2'd2, 5'd4, 5'd2, 16'h0, 1'b1, 1'b0, 16'h8001, 1'b0);
        run_frame(2'd0, 2'd3, 5'd7, 5'd30, 16'h0, 1'b1, 1'b0, 16'h7FFE, 1'b0);
        run_frame(2'd0, 2'd2, 5'd7, 5'd30, 16'h0, 1'b1, 1'b0, 16'hBEEF, 1'b0);
        // Failed read, then a write leaves status set, then a good read clears (R7)
        run_frame(2'd1, 2'd2, 5'd6, 5'd1, 16'h0, 1'b1, 1'b1, 16'h1234, 1'b0);
        run_frame(2'd1, 2'd1, 5'd6, 5'd1, 16'h3C96, 1'b0, 1'b0, 16'h0, 1'b0);
        reg_rd(5'h10, v);
        check(v == 32'd1, "R7 status kept by write", 64'(v), 64'd1);
        run_frame(2'd1, 2'd2, 5'd6, 5'd1, 16'h0, 1'b1, 1'b0, 16'h0F0F, 1'b0);
        // Command write during a frame (R9)
        run_frame(2'd1, 2'd1, 5'd12, 5'd13, 16'h3C96, 1'b0, 1'b0, 16'h0, 1'b1);
        // Command without start (R11)
        reg_wr(5'h00, {17'd0, 1'b0, 2'd1, 2'd2, 5'd21, 5'd10});
        repeat (3 * DIV) begin
            reg_rd(5'h00, v);
            if (v[14] || mdc) break;
            @(negedge clk);
        end
        check(!v[14] && !mdc, "R11 no frame started", {62'd0, v[14], mdc}, 64'd0);
        check(v[13:0] == {2'd1, 2'd2, 5'd21, 5'd10}, "R11 fields stored",
              64'(v[13:0]), 64'({2'd1, 2'd2, 5'd21, 5'd10}));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule